// File: doc/BRIEF.md
# Storage Channel Register File and Window Decoder

This block is the register front end of a mass-storage channel adapter that sits on a 16-bit peripheral bus. The bus can address words or single bytes. Each request carries a byte address inside the adapter's window. The word part of that address is decoded in one of three ways:

- It selects a local register: primary control/status, word count, bus address, secondary control/status, data buffer, address extension or tertiary control/status.
- It is forwarded to the attached drive as a numbered drive register.
- It is rejected with a bus error.

Local registers merge byte writes, mask their read-back values and keep the interrupt-enable bit and the two address-extension bits consistent across registers. A few command patterns act directly: a controller clear, an error clear, the start of a transfer and the program-error trap. The forwarding port is combinational. The drive returns its read data in the same cycle, and the response is registered one cycle after the request.

Top module: `chan_regfile`

## Requirements
- R1: After reset, primary status reads 0x0080 (DONE bit 7 set, the low six bits supplied by drive register 0), word count, bus address, data buffer, extension and tertiary status read 0, and secondary status reads 0x00C0. Word offsets 0, 1, 2, 4 and 9 select primary status, word count, bus address, secondary status and data buffer.
- R2: Drive-forwarded offsets map as follows: 3 to drive register 5, 5 to 1, 6 to 2, 7 to 4, 8 to 7, 10 to 3 and 11 to 6. Offsets from 12 up to the window's third-last word map to register (offset - 4). A read of a forwarded offset returns `drv_rdata`, and a write presents the write value on `fwd_wdata`.
- R3: The last two words of the window (offsets WIN_WORDS-2 and WIN_WORDS-1) are the extension and tertiary status when `ext_mode`=1. With `ext_mode`=0 they give a bus error, and so does every offset at or beyond WIN_WORDS. An error access sets `rsp_err`, raises no `fwd_valid` and changes no register.
- R4: A byte access uses `req_wdata[7:0]`. An even address (bit 0 of the address = 0) writes the low byte and an odd address shifts the data into the high byte, so byte writes to word count, bus address and data buffer leave the other byte intact.
- R5: An odd-byte write to the extension or tertiary status registers changes nothing.
- R6: Bus address bit 0 always reads 0.
- R7: Secondary status always reads with bits 6 and 7 set. Only bits 4:0, 9 and 13 are writable.
- R8: Writing bit 5 of secondary status returns every register to its reset value and does not store the written value.
- R9: Interrupt enable (bit 6) is one bit seen in both primary and tertiary status, and a write to either updates both. Tertiary status bits 3:0 are plain storage.
- R10: Primary status bits 9:8 equal extension bits 1:0. An extension write updates them. A high-byte write to primary status updates them only while DONE is set.
- R11: Primary status bits 15 and 14 read 1 whenever any of secondary status bits 15:8 is set. A primary status write with bit 14 set clears secondary bits 15:8.
- R12: A low-byte primary status write with bit 0 set and bits 5:1 >= 20 is a transfer start. With DONE clear it sets secondary status bit 10 and forwards nothing. With DONE set it clears DONE and secondary bits 15:8, and forwards bits 5:0 to drive register 0, as every other low-byte primary write does.
- R13: Every request gets `rsp_valid` exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1: last two window words exist (extension, tertiary status) |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 write, 0 read |
| req_byte | input | 1 | 1 byte access, 0 word access |
| req_addr | input | ADDR_W | Byte address inside the window |
| req_wdata | input | 16 | Write data (byte in bits 7:0 for byte access) |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Bus error for non-existent address |
| rsp_rdata | output | 16 | Read data (0 for writes and errors) |
| fwd_valid | output | 1 | Access forwarded to the drive this cycle |
| fwd_write | output | 1 | Forwarded access is a write |
| fwd_reg | output | XREG_W | Drive register number |
| fwd_wdata | output | 16 | Forwarded write value |
| drv_rdata | input | 16 | Drive register read data, same cycle as fwd_reg |

## Verification
The bench builds the block with WIN_WORDS=22 and XREG_W=5. This gives a 6-bit byte address, so a sweep of all 64 byte addresses in both modes covers every word in the window. It also covers the two mode-dependent top words and ten addresses past the end. For every address the sweep compares the error flag, the forwarding strobe and the drive register number against an arithmetic model. Because the window is small, the same configuration also reaches every local register, and directed sequences there cover the lane merges, the mirrored bits, the DONE-gated paths and the clear commands.

// File: rtl/chan_regs_pkg.sv
package chan_regs_pkg;
  localparam int DW = 16;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CS1, SEL_WC, SEL_BA, SEL_CS2,
    SEL_DB, SEL_AE, SEL_CS3, SEL_EXT
  } sel_e;

  localparam int B_GO     = 0;
  localparam int B_CLR    = 5;
  localparam int B_IE     = 6;
  localparam int B_DONE   = 7;
  localparam int B_PGE    = 10;
  localparam int B_ERRCLR = 14;
  localparam int AE_W     = 6;
  localparam int IPCK_W   = 4;
  localparam logic [4:0]  XFER_MIN   = 5'd20;
  localparam logic [15:0] CS2_WMASK  = 16'h221F;
  localparam logic [15:0] CS2_RDYSET = 16'h00C0;
endpackage

// File: rtl/chan_addr_decode.sv
module chan_addr_decode
  import chan_regs_pkg::*;
#(
  parameter int WIN_WORDS = 22,
  parameter int XREG_W    = 5,
  localparam int OFS_W    = $clog2(WIN_WORDS)
) (
  input  logic [OFS_W-1:0]  word_ofs,
  input  logic              ext_mode,
  output sel_e              sel,
  output logic [XREG_W-1:0] xreg
);
  always_comb begin
    int unsigned w;
    w    = 32'(word_ofs);
    sel  = SEL_NONE;
    xreg = '0;
    if (w < 32'(WIN_WORDS)) begin
      if (w >= 32'(WIN_WORDS - 2)) begin
        if (ext_mode) sel = (w == 32'(WIN_WORDS - 2)) ? SEL_AE : SEL_CS3;
      end else begin
        case (w)
          0:  sel = SEL_CS1;
          1:  sel = SEL_WC;
          2:  sel = SEL_BA;
          4:  sel = SEL_CS2;
          9:  sel = SEL_DB;
          3:  begin sel = SEL_EXT; xreg = XREG_W'(5); end
          5:  begin sel = SEL_EXT; xreg = XREG_W'(1); end
          6:  begin sel = SEL_EXT; xreg = XREG_W'(2); end
          7:  begin sel = SEL_EXT; xreg = XREG_W'(4); end
          8:  begin sel = SEL_EXT; xreg = XREG_W'(7); end
          10: begin sel = SEL_EXT; xreg = XREG_W'(3); end
          11: begin sel = SEL_EXT; xreg = XREG_W'(6); end
          default: begin sel = SEL_EXT; xreg = XREG_W'(w - 4); end
        endcase
      end
    end
  end
endmodule

// File: rtl/chan_byte_lanes.sv
module chan_byte_lanes
  import chan_regs_pkg::*;
(
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] wdata,
  input  logic          wbyte,
  input  logic          odd,
  output logic [DW-1:0] wval,
  output logic [DW-1:0] merged,
  output logic [1:0]    lane_en
);
  always_comb begin
    if (!wbyte)   wval = wdata;
    else if (odd) wval = {wdata[7:0], 8'h00};
    else          wval = {8'h00, wdata[7:0]};
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_en[g] = !wbyte || (g == 1 ? odd : !odd);
    assign merged[g*8 +: 8] = lane_en[g] ? wval[g*8 +: 8] : cur[g*8 +: 8];
  end
endmodule

// File: rtl/chan_reg_core.sv
module chan_reg_core
  import chan_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  sel_e          sel,
  input  logic          wbyte,
  input  logic          odd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] loc_rdata,
  output logic [DW-1:0] wval,
  output logic          cs1_fwd_ok
);
  logic            ie1_q, ie3_q, done_q;
  logic [1:0]      ext_q;
  logic [DW-1:0]   wc_q, ba_q, cs2_q, db_q;
  logic [AE_W-1:0] ae_q;
  logic [IPCK_W-1:0] ipck_q;

  logic [DW-1:0] cur, merged;
  logic [1:0]    lane_en;
  logic          xfer, clr_now, tre;

  always_comb begin
    case (sel)
      SEL_WC:  cur = wc_q;
      SEL_BA:  cur = ba_q;
      SEL_CS2: cur = cs2_q;
      SEL_DB:  cur = db_q;
      default: cur = '0;
    endcase
  end

  chan_byte_lanes i_lanes (
    .cur(cur), .wdata(wdata), .wbyte(wbyte), .odd(odd),
    .wval(wval), .merged(merged), .lane_en(lane_en)
  );

  assign xfer       = wval[B_GO] && (wval[5:1] >= XFER_MIN);
  assign clr_now    = wr_en && (sel == SEL_CS2) && merged[B_CLR];
  assign tre        = |cs2_q[15:8];
  assign cs1_fwd_ok = lane_en[0] && !(xfer && !done_q);

  always_ff @(posedge clk) begin
    if (rst || clr_now) begin
      ie1_q  <= 1'b0;
      ie3_q  <= 1'b0;
      done_q <= 1'b1;
      ext_q  <= '0;
      wc_q   <= '0;
      ba_q   <= '0;
      cs2_q  <= '0;
      db_q   <= '0;
      ae_q   <= '0;
      ipck_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CS1: begin
          if (wval[B_ERRCLR]) cs2_q[15:8] <= '0;
          if (lane_en[1] && done_q) begin
            ext_q     <= wval[9:8];
            ae_q[1:0] <= wval[9:8];
          end
          if (lane_en[0]) begin
            ie1_q <= wval[B_IE];
            ie3_q <= wval[B_IE];
            if (xfer) begin
              if (!done_q) cs2_q[B_PGE] <= 1'b1;
              else begin
                done_q      <= 1'b0;
                cs2_q[15:8] <= '0;
              end
            end
          end
        end
        SEL_WC:  wc_q <= merged;
        SEL_BA:  ba_q <= merged & 16'hFFFE;
        SEL_DB:  db_q <= merged;
        SEL_CS2: cs2_q <= (cs2_q & ~CS2_WMASK) | (merged & CS2_WMASK);
        SEL_AE: if (lane_en[0]) begin
          ae_q  <= wval[AE_W-1:0];
          ext_q <= wval[1:0];
        end
        SEL_CS3: if (lane_en[0]) begin
          ipck_q <= wval[IPCK_W-1:0];
          ie1_q  <= wval[B_IE];
          ie3_q  <= wval[B_IE];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_CS1: loc_rdata = {tre, tre, 4'b0, ext_q, done_q, ie1_q, 6'b0};
      SEL_WC:  loc_rdata = wc_q;
      SEL_BA:  loc_rdata = {ba_q[15:1], 1'b0};
      SEL_CS2: loc_rdata = (cs2_q & ~16'h0020) | CS2_RDYSET;
      SEL_DB:  loc_rdata = db_q;
      SEL_AE:  loc_rdata = {{(DW-AE_W){1'b0}}, ae_q};
      SEL_CS3: loc_rdata = {9'b0, ie3_q, 2'b0, ipck_q};
      default: loc_rdata = '0;
    endcase
  end

  // R9: both copies of interrupt enable agree
  p_ie_mirror_r9: assert property (@(posedge clk) disable iff (rst)
    ie1_q == ie3_q);
  // R10: extension bits agree between the two registers
  p_ext_mirror_r10: assert property (@(posedge clk) disable iff (rst)
    ext_q == ae_q[1:0]);
  // R10: primary-status writes cannot move the extension bits while DONE is clear
  p_ext_lock_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CS1 && !done_q) |=> $stable(ext_q));
  // R12: transfer start while busy raises program error
  p_pge_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CS1 && lane_en[0] && xfer && !done_q) |=> cs2_q[B_PGE]);
  // R12: accepted transfer start drops DONE
  p_done_clr_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CS1 && lane_en[0] && xfer && done_q) |=> !done_q);
endmodule

// File: rtl/chan_regfile.sv
module chan_regfile
  import chan_regs_pkg::*;
#(
  parameter int WIN_WORDS = 22,
  parameter int XREG_W    = 5,
  localparam int OFS_W    = $clog2(WIN_WORDS),
  localparam int ADDR_W   = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [15:0]       rsp_rdata,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [XREG_W-1:0] fwd_reg,
  output logic [15:0]       fwd_wdata,
  input  logic [15:0]       drv_rdata
);
  sel_e              sel;
  logic [XREG_W-1:0] xreg;
  logic [DW-1:0]     loc_rdata, wval;
  logic              cs1_fwd_ok, is_local, wr_en, fwd_cs1;

  chan_addr_decode #(.WIN_WORDS(WIN_WORDS), .XREG_W(XREG_W)) i_dec (
    .word_ofs(req_addr[ADDR_W-1:1]), .ext_mode(ext_mode),
    .sel(sel), .xreg(xreg)
  );

  assign is_local = (sel != SEL_NONE) && (sel != SEL_EXT);
  assign wr_en    = req_valid && req_write && is_local;

  chan_reg_core i_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel),
    .wbyte(req_byte), .odd(req_addr[0]), .wdata(req_wdata),
    .loc_rdata(loc_rdata), .wval(wval), .cs1_fwd_ok(cs1_fwd_ok)
  );

  assign fwd_cs1   = (sel == SEL_CS1) && (!req_write || cs1_fwd_ok);
  assign fwd_valid = req_valid && ((sel == SEL_EXT) || fwd_cs1);
  assign fwd_write = req_write;
  assign fwd_reg   = (sel == SEL_EXT) ? xreg : '0;
  assign fwd_wdata = (sel == SEL_EXT) ? wval : {10'b0, wval[5:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && (sel == SEL_NONE);
      if (!req_valid || req_write || sel == SEL_NONE) rsp_rdata <= '0;
      else if (sel == SEL_EXT)                       rsp_rdata <= drv_rdata;
      else if (sel == SEL_CS1)                       rsp_rdata <= loc_rdata | {10'b0, drv_rdata[5:0]};
      else                                           rsp_rdata <= loc_rdata;
    end
  end

  // R13: every request is answered next cycle
  p_rsp_lat_r13: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R3: non-existent address answers with an error
  p_err_rsp_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sel == SEL_NONE) |=> rsp_err);
  // R3: non-existent address never reaches the drive
  p_err_nofwd_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sel == SEL_NONE) |-> !fwd_valid);
  // R2: only drive-side offsets carry a nonzero drive register number
  p_fwd_reg_r2: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && sel != SEL_EXT) |-> (fwd_reg == '0));
endmodule

// File: tb/test_chan_regfile.sv
module test_chan_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 22;
  localparam int XW  = 5;

  logic clk = 1'b0, rst = 1'b1, ext_mode = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [5:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid, rsp_err, fwd_valid, fwd_write;
  logic [15:0] rsp_rdata, fwd_wdata, drv_rdata;
  logic [XW-1:0] fwd_reg;
  int n_chk = 0, n_bad = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign drv_rdata = 16'hD000 | {11'b0, fwd_reg};

  chan_regfile #(.WIN_WORDS(WIN), .XREG_W(XW)) i_chan_regfile (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .req_valid(req_valid),
    .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .fwd_valid(fwd_valid), .fwd_write(fwd_write),
    .fwd_reg(fwd_reg), .fwd_wdata(fwd_wdata), .drv_rdata(drv_rdata)
  );

  logic [15:0] a_rd, a_fd;
  logic a_er, a_fv, a_rv;
  logic [XW-1:0] a_fr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic byt, input int addr, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_byte = byt;
    req_addr = 6'(addr); req_wdata = d;
    #1;
    a_fv = fwd_valid; a_fr = fwd_reg; a_fd = fwd_wdata;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    a_rv = rsp_valid; a_er = rsp_err; a_rd = rsp_rdata;
  endtask

  task automatic rd_chk(input string tag, input int addr, input logic [15:0] exp);
    acc(1'b0, 1'b0, addr, 16'h0);
    chk(tag, {a_er, a_rd}, {1'b0, exp});
  endtask

  // Model of the window map: returns -2 error, -1 local, else drive register
  function automatic int model_map(input int w, input logic m);
    if (w >= WIN) return -2;
    if (w >= WIN - 2) return m ? -1 : -2;
    case (w)
      0, 1, 2, 4, 9: return -1;
      3: return 5; 5: return 1; 6: return 2; 7: return 4;
      8: return 7; 10: return 3; 11: return 6;
      default: return w - 4;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset values
    rd_chk("R1 cs1 reset", 0, 16'h0080);
    rd_chk("R1 wc reset", 2, 16'h0000);
    rd_chk("R1 ba reset", 4, 16'h0000);
    rd_chk("R7 cs2 reset", 8, 16'h00C0);
    rd_chk("R1 db reset", 18, 16'h0000);
    rd_chk("R1 ae reset", 40, 16'h0000);
    rd_chk("R1 cs3 reset", 42, 16'h0000);
    chk("R13 rsp_valid", a_rv, 1'b1);

    // R2/R3 sweep of every byte address, both modes
    for (int m = 0; m < 2; m++) begin
      ext_mode = m[0];
      for (int a = 0; a < 64; a++) begin
        int e;
        e = model_map(a / 2, m[0]);
        acc(1'b0, 1'b0, a, 16'h0);
        chk($sformatf("R3 err m%0d a%0d", m, a), a_er, (e == -2));
        if (e >= 0) begin
          chk($sformatf("R2 fwd m%0d a%0d", m, a), {a_fv, 11'b0, a_fr}, {1'b1, 11'b0, XW'(e)});
          chk($sformatf("R2 data m%0d a%0d", m, a), a_rd, 16'hD000 | 16'(e));
        end else if (e == -2) begin
          chk($sformatf("R3 nofwd m%0d a%0d", m, a), a_fv, 1'b0);
        end
      end
    end
    ext_mode = 1'b1;

    // R4 byte lanes on word count and data buffer
    acc(1'b1, 1'b0, 2, 16'h1234);
    acc(1'b1, 1'b1, 2, 16'h00AB);
    rd_chk("R4 wc even byte", 2, 16'h12AB);
    acc(1'b1, 1'b1, 3, 16'h00CD);
    rd_chk("R4 wc odd byte", 2, 16'hCDAB);
    acc(1'b1, 1'b1, 19, 16'h0077);
    rd_chk("R4 db odd byte", 18, 16'h7700);
    // R6
    acc(1'b1, 1'b0, 4, 16'hFFFF);
    rd_chk("R6 ba bit0", 4, 16'hFFFE);
    acc(1'b1, 1'b1, 4, 16'h0033);
    rd_chk("R6 ba byte", 4, 16'hFF32);
    // R2/R4 forwarded odd byte write
    acc(1'b1, 1'b1, 7, 16'h005A);
    chk("R2 fwd write", {a_fv, 11'b0, a_fr, a_fd}, {1'b1, 11'b0, XW'(5), 16'h5A00});

    // R10 extension mirror, R5 odd byte ignore, R9 IE mirror
    acc(1'b1, 1'b0, 40, 16'hFFFF);
    rd_chk("R10 ae value", 40, 16'h003F);
    rd_chk("R10 cs1 ext", 0, 16'h0380);
    acc(1'b1, 1'b1, 41, 16'h0000);
    rd_chk("R5 ae odd ignored", 40, 16'h003F);
    acc(1'b1, 1'b0, 42, 16'h004F);
    rd_chk("R9 cs3 write", 42, 16'h004F);
    rd_chk("R9 cs1 ie", 0, 16'h03C0);
    acc(1'b1, 1'b1, 43, 16'h0000);
    rd_chk("R5 cs3 odd ignored", 42, 16'h004F);
    acc(1'b1, 1'b0, 0, 16'h0300);
    rd_chk("R9 cs3 ie from cs1", 42, 16'h000F);

    // R7 writable mask, R11 error summary and clear
    acc(1'b1, 1'b0, 8, 16'hFFDF);
    rd_chk("R7 cs2 mask", 8, 16'h22DF);
    rd_chk("R11 cs1 err bits", 0, 16'hC380);
    acc(1'b1, 1'b0, 0, 16'h4300);
    rd_chk("R11 cs2 cleared", 8, 16'h00DF);
    rd_chk("R11 cs1 cleared", 0, 16'h0380);

    // R12 transfer start with DONE set
    acc(1'b1, 1'b0, 0, 16'h0329);
    chk("R12 fwd go", {a_fv, a_fd}, {1'b1, 16'h0029});
    rd_chk("R12 done cleared", 0, 16'h0300);
    // R10 high-byte write ignored while DONE clear
    acc(1'b1, 1'b1, 1, 16'h0000);
    rd_chk("R10 ext locked", 0, 16'h0300);
    rd_chk("R10 ae kept", 40, 16'h003F);
    // R12 transfer start while busy
    acc(1'b1, 1'b0, 0, 16'h0029);
    chk("R12 no fwd", a_fv, 1'b0);
    rd_chk("R12 pge", 8, 16'h04DF);
    rd_chk("R12 cs1 err", 0, 16'hC300);

    // R3 error accesses change nothing
    acc(1'b1, 1'b0, 50, 16'hFFFF);
    chk("R3 beyond err", a_er, 1'b1);
    ext_mode = 1'b0;
    acc(1'b1, 1'b0, 40, 16'h0000);
    chk("R3 basic err", {a_er, a_fv}, {1'b1, 1'b0});
    ext_mode = 1'b1;
    rd_chk("R3 ae unchanged", 40, 16'h003F);
    rd_chk("R3 wc unchanged", 2, 16'hCDAB);

    // R8 controller clear
    acc(1'b1, 1'b1, 8, 16'h0020);
    rd_chk("R8 cs1", 0, 16'h0080);
    rd_chk("R8 cs2", 8, 16'h00C0);
    rd_chk("R8 wc", 2, 16'h0000);
    rd_chk("R8 ae", 40, 16'h0000);
    rd_chk("R8 cs3", 42, 16'h0000);
    rd_chk("R8 db", 18, 16'h0000);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule